// File: doc/BRIEF.md
# Device Address Window Validator

This block decides whether a memory access request may proceed. A request carries a start address and a byte length. The block strips the segment bits from the address to get a physical address. It then tests the whole byte range against three device windows: main memory, a boot ROM, and an auxiliary ROM. It returns a registered pass or bus-error verdict, the code of the window that matched, and the ROM image that holds the first byte when the boot window matched.

Window geometry comes from a small register file that software can write and read back. Main memory uses a usable-size register. The auxiliary ROM uses a base register plus a delay register. The boot ROM has a fixed base and only a delay register. For both ROMs, the low five bits of the delay register give the log2 of the window size. A strap input swaps which of two ROM images sits in the lower and upper halves of the boot region.

Top module: `addr_window_validator`

## Requirements
- R1: Bits 31:29 of `req_addr` are cleared to form the physical address before any comparison, so 0xB0000000 is treated as 0x10000000.
- R2: A request is rejected (`rsp_ok`=0, `rsp_win`=0) when `req_addr[2:0]` is nonzero, when `req_len[2:0]` is nonzero, or when `req_len` is zero.
- R3: A request passes only if every byte from physical start to start+len-1 lies inside one window. The end is computed in 34 bits, so a length of up to 0xFFFFFFF8 cannot wrap. Otherwise the result is a bus error with `rsp_win`=0.
- R4: The main memory window covers physical [0, limit). The limit register (`cfg_sel`=0) resets to 0x007FFF00.
- R5: The boot window starts at physical 0x1FC00000 and spans 1<<D bytes, where D is bits 4:0 of the boot delay register (`cfg_sel`=3). That register resets to 0x00162456, which gives 4 MB.
- R6: The auxiliary window starts at the base register (`cfg_sel`=1, reset 0x1FA00000) and spans 1<<D bytes, where D is bits 4:0 of the auxiliary delay register (`cfg_sel`=2). That register resets to 0x00152E35, which gives 2 MB.
- R7: Windows are tried in the order main, boot, auxiliary, and the first window that wholly contains the range wins. `rsp_win` encodes 0 = none, 1 = main, 2 = boot, 3 = auxiliary.
- R8: On a boot-window pass, `rsp_img` equals physical bit 21 of the start XOR `rom_swap`. With `rom_swap`=0, image 0 is at 0x1FC00000 and image 1 is at 0x1FE00000; `rom_swap`=1 reverses them. `rsp_img` is 0 for every other result.
- R9: `rsp_valid` rises in the cycle after `req_valid`. When `rsp_valid` is low, `rsp_ok`, `rsp_win` and `rsp_img` are 0.
- R10: `cfg_rdata` shows the register selected by `cfg_sel` combinationally. A write with `cfg_we`=1 updates the register at the next clock edge, and the register reads back unchanged.
- R11: After reset, `rsp_valid` is 0 and all four registers hold their stated reset values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| rom_swap | input | 1 | Strap that swaps the two boot ROM images |
| cfg_we | input | 1 | Configuration write enable |
| cfg_sel | input | 2 | Configuration register select |
| cfg_wdata | input | 32 | Configuration write data |
| cfg_rdata | output | 32 | Selected configuration register |
| req_valid | input | 1 | Request present |
| req_addr | input | 32 | Request start address (segmented) |
| req_len | input | 32 | Request length in bytes |
| rsp_valid | output | 1 | Verdict present |
| rsp_ok | output | 1 | 1 = pass, 0 = bus error |
| rsp_win | output | 2 | Matched window code |
| rsp_img | output | 1 | Boot ROM image holding the first byte |

## Verification
Assertions check on every cycle that the response follows the request by one cycle, that an idle response carries zero fields, and that misaligned requests are always rejected. They also check that a pass always names a window, that the image bit is set only on boot hits, and that a configuration write is held in the register. The bench sweeps segment prefixes, offsets around each window edge, and a range of lengths. It compares each result with an arithmetic model, which is the only way to show correct range containment, the absence of end-address wrap, window priority under overlap, and image swapping. Register rewrites then move, resize and overlap the windows, and the sweeps are repeated.

// File: rtl/awv_pkg.sv
package awv_pkg;

    localparam int ADDR_W     = 32;
    localparam int SEG_BITS   = 3;
    localparam int ALIGN_BITS = 3;
    localparam int CMP_W      = ADDR_W + 2;
    localparam int NWIN       = 3;
    localparam int SIZE_FIELD = 5;
    localparam int IMG_BIT    = 21;

    localparam logic [ADDR_W-1:0] BOOT_BASE     = 32'h1FC0_0000;
    localparam logic [ADDR_W-1:0] RST_MEM_LIMIT = 32'h007F_FF00;
    localparam logic [ADDR_W-1:0] RST_AUX_BASE  = 32'h1FA0_0000;
    localparam logic [ADDR_W-1:0] RST_AUX_DLY   = 32'h0015_2E35;
    localparam logic [ADDR_W-1:0] RST_BOOT_DLY  = 32'h0016_2456;

    typedef enum logic [1:0] {
        SEL_MEM_LIMIT = 2'd0,
        SEL_AUX_BASE  = 2'd1,
        SEL_AUX_DLY   = 2'd2,
        SEL_BOOT_DLY  = 2'd3
    } cfg_sel_e;

    typedef enum logic [1:0] {
        WIN_NONE = 2'd0,
        WIN_MAIN = 2'd1,
        WIN_BOOT = 2'd2,
        WIN_AUX  = 2'd3
    } win_e;

    typedef struct packed {
        logic ok;
        win_e win;
        logic img;
    } verdict_t;

    typedef struct packed {
        logic [CMP_W-1:0] lo;
        logic [CMP_W-1:0] hi;
    } span_t;

    function automatic logic [ADDR_W-1:0] to_phys(input logic [ADDR_W-1:0] a);
        return {{SEG_BITS{1'b0}}, a[ADDR_W-SEG_BITS-1:0]};
    endfunction

    function automatic logic [CMP_W-1:0] win_top(input logic [ADDR_W-1:0] base,
                                                 input logic [ADDR_W-1:0] dly);
        logic [CMP_W-1:0] sz;
        sz = {{(CMP_W-1){1'b0}}, 1'b1} << dly[SIZE_FIELD-1:0];
        return {2'b00, base} + sz;
    endfunction

endpackage

// File: rtl/awv_cfg_regs.sv
module awv_cfg_regs
    import awv_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              we,
    input  logic [1:0]        sel,
    input  logic [ADDR_W-1:0] wdata,
    output logic [ADDR_W-1:0] rdata,
    output logic [ADDR_W-1:0] mem_limit,
    output logic [ADDR_W-1:0] aux_base,
    output logic [ADDR_W-1:0] aux_dly,
    output logic [ADDR_W-1:0] boot_dly
);
    logic [ADDR_W-1:0] regs [4];

    always_ff @(posedge clk) begin
        if (rst) begin
            regs[SEL_MEM_LIMIT] <= RST_MEM_LIMIT;
            regs[SEL_AUX_BASE]  <= RST_AUX_BASE;
            regs[SEL_AUX_DLY]   <= RST_AUX_DLY;
            regs[SEL_BOOT_DLY]  <= RST_BOOT_DLY;
        end else if (we) begin
            regs[sel] <= wdata;
        end
    end

    assign rdata     = regs[sel];
    assign mem_limit = regs[SEL_MEM_LIMIT];
    assign aux_base  = regs[SEL_AUX_BASE];
    assign aux_dly   = regs[SEL_AUX_DLY];
    assign boot_dly  = regs[SEL_BOOT_DLY];

    assert_readback_R10: assert property (@(posedge clk) disable iff (rst)
        we |=> regs[$past(sel)] == $past(wdata));

endmodule

// File: rtl/awv_window.sv
module awv_window
    import awv_pkg::*;
(
    input  span_t req,
    input  span_t win,
    output logic  hit
);
    assign hit = (req.lo >= win.lo) && (req.hi <= win.hi);
endmodule

// File: rtl/addr_window_validator.sv
module addr_window_validator
    import awv_pkg::*;
(
    input  logic        clk,
    input  logic        rst,
    input  logic        rom_swap,
    input  logic        cfg_we,
    input  logic [1:0]  cfg_sel,
    input  logic [31:0] cfg_wdata,
    output logic [31:0] cfg_rdata,
    input  logic        req_valid,
    input  logic [31:0] req_addr,
    input  logic [31:0] req_len,
    output logic        rsp_valid,
    output logic        rsp_ok,
    output logic [1:0]  rsp_win,
    output logic        rsp_img
);
    logic [ADDR_W-1:0] mem_limit, aux_base, aux_dly, boot_dly;

    awv_cfg_regs u_regs (
        .clk(clk), .rst(rst), .we(cfg_we), .sel(cfg_sel), .wdata(cfg_wdata),
        .rdata(cfg_rdata), .mem_limit(mem_limit), .aux_base(aux_base),
        .aux_dly(aux_dly), .boot_dly(boot_dly)
    );

    logic [ADDR_W-1:0] phys;
    logic              shape_ok;
    span_t             rspan;
    span_t             wspan [NWIN];
    logic [NWIN-1:0]   hits;
    verdict_t          next_v, cur_v;

    assign phys     = to_phys(req_addr);
    assign shape_ok = (req_addr[ALIGN_BITS-1:0] == '0) &&
                      (req_len[ALIGN_BITS-1:0] == '0) && (req_len != '0);
    assign rspan.lo = {2'b00, phys};
    assign rspan.hi = {2'b00, phys} + {2'b00, req_len};

    assign wspan[0].lo = '0;
    assign wspan[0].hi = {2'b00, mem_limit};
    assign wspan[1].lo = {2'b00, BOOT_BASE};
    assign wspan[1].hi = win_top(BOOT_BASE, boot_dly);
    assign wspan[2].lo = {2'b00, aux_base};
    assign wspan[2].hi = win_top(aux_base, aux_dly);

    for (genvar i = 0; i < NWIN; i++) begin : g_win
        awv_window u_win (.req(rspan), .win(wspan[i]), .hit(hits[i]));
    end

    always_comb begin
        next_v = '0;
        if (shape_ok) begin
            for (int i = NWIN - 1; i >= 0; i--) begin
                if (hits[i]) begin
                    next_v.ok  = 1'b1;
                    next_v.win = win_e'(i + 1);
                end
            end
            if (next_v.win == WIN_BOOT)
                next_v.img = phys[IMG_BIT] ^ rom_swap;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            rsp_valid <= 1'b0;
            cur_v     <= '0;
        end else begin
            rsp_valid <= req_valid;
            cur_v     <= req_valid ? next_v : '0;
        end
    end

    assign rsp_ok  = cur_v.ok;
    assign rsp_win = cur_v.win;
    assign rsp_img = cur_v.img;

    assert_latency_R9: assert property (@(posedge clk) disable iff (rst)
        req_valid |=> rsp_valid);
    assert_idle_quiet_R9: assert property (@(posedge clk) disable iff (rst)
        !rsp_valid |-> (!rsp_ok && rsp_win == 2'd0 && !rsp_img));
    assert_misaligned_rejected_R2: assert property (@(posedge clk) disable iff (rst)
        (req_valid && (req_addr[2:0] != 3'd0 || req_len[2:0] != 3'd0 || req_len == 32'd0))
        |=> (!rsp_ok && rsp_win == 2'd0));
    assert_ok_has_window_R7: assert property (@(posedge clk) disable iff (rst)
        rsp_ok == (rsp_win != 2'd0));
    assert_img_only_boot_R8: assert property (@(posedge clk) disable iff (rst)
        rsp_img |-> (rsp_ok && rsp_win == 2'd2));

endmodule

// File: tb/tb_addr_window_validator.sv
module tb_addr_window_validator;
    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        rom_swap = 1'b0;
    logic        cfg_we = 1'b0;
    logic [1:0]  cfg_sel = 2'd0;
    logic [31:0] cfg_wdata = '0;
    logic [31:0] cfg_rdata;
    logic        req_valid = 1'b0;
    logic [31:0] req_addr = '0;
    logic [31:0] req_len = '0;
    logic        rsp_valid, rsp_ok, rsp_img;
    logic [1:0]  rsp_win;

    int n_cmp = 0;
    int n_bad = 0;

    longint m_limit, m_abase, m_adly, m_bdly;

    addr_window_validator dut (
        .clk(clk), .rst(rst), .rom_swap(rom_swap), .cfg_we(cfg_we),
        .cfg_sel(cfg_sel), .cfg_wdata(cfg_wdata), .cfg_rdata(cfg_rdata),
        .req_valid(req_valid), .req_addr(req_addr), .req_len(req_len),
        .rsp_valid(rsp_valid), .rsp_ok(rsp_ok), .rsp_win(rsp_win), .rsp_img(rsp_img)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    initial begin
        #(CLK_PERIOD * 150000);
        n_cmp++; n_bad++;
        $display("FAIL watchdog: run hung, actual=running expected=done");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    task automatic check(input string tag, input longint act, input longint exp);
        n_cmp++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s: actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic cfg_write(input logic [1:0] s, input logic [31:0] d);
        @(negedge clk);
        cfg_we = 1'b1; cfg_sel = s; cfg_wdata = d;
        @(negedge clk);
        cfg_we = 1'b0;
        case (s)
            2'd0: m_limit = d;
            2'd1: m_abase = d;
            2'd2: m_adly  = d;
            default: m_bdly = d;
        endcase
        #1 check("R10 readback", cfg_rdata, d);
    endtask

    // Arithmetic model of the verdict: {ok, win[1:0], img}
    function automatic logic [3:0] model(input logic [31:0] a, input logic [31:0] l,
                                         input logic sw);
        longint p, e;
        p = longint'(a) & 64'h1FFF_FFFF;
        e = p + longint'(l);
        if (a[2:0] != 0 || l[2:0] != 0 || l == 0) return 4'b0000;
        if (e <= m_limit) return 4'b1010;
        if (p >= 64'h1FC0_0000 && e <= 64'h1FC0_0000 + (64'd1 << (m_bdly & 31)))
            return {3'b1_10, p[21] ^ sw};
        if (p >= m_abase && e <= m_abase + (64'd1 << (m_adly & 31))) return 4'b1110;
        return 4'b0000;
    endfunction

    task automatic request(input logic [31:0] a, input logic [31:0] l, input logic sw);
        logic [3:0] exp;
        string tag;
        exp = model(a, l, sw);
        if (a[2:0] != 0 || l[2:0] != 0 || l == 0) tag = "R2 shape";
        else if (exp[2:1] == 2'd1) tag = "R4 main";
        else if (exp[2:1] == 2'd2) tag = "R5 boot R8 image";
        else if (exp[2:1] == 2'd3) tag = "R6 aux";
        else tag = "R3 range";
        @(negedge clk);
        req_valid = 1'b1; req_addr = a; req_len = l; rom_swap = sw;
        @(negedge clk);
        req_valid = 1'b0;
        check("R9 valid", rsp_valid, 1);
        check(tag, {rsp_ok, rsp_win, rsp_img}, exp);
    endtask

    task automatic sweep(input logic sw);
        logic [31:0] bases [8] = '{32'h0, 32'h007F_FF00, 32'h1FC0_0000, 32'h1FA0_0000,
                                   32'h1FBF_FF00, 32'h1FFF_FF00, 32'h1FDF_FFF8, 32'h1E00_0000};
        logic [31:0] lens [6] = '{32'd0, 32'd3, 32'd8, 32'h100, 32'h20_0000, 32'hFFFF_FFF8};
        logic [2:0]  segs [3] = '{3'd0, 3'd4, 3'd5};
        for (int s = 0; s < 3; s++)          // R1: segment bits vary
            for (int b = 0; b < 8; b++)
                for (int o = -16; o <= 16; o += 8)
                    for (int n = 0; n < 6; n++) begin
                        logic [31:0] a;
                        a = bases[b] + 32'(o);
                        a = {segs[s], a[28:0]};
                        request(a, lens[n], sw);
                    end
    endtask

    initial begin
        m_limit = 32'h007F_FF00; m_abase = 32'h1FA0_0000;
        m_adly = 32'h0015_2E35;  m_bdly = 32'h0016_2456;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        #1;
        check("R11 reset valid", rsp_valid, 0);
        cfg_sel = 2'd0; #1 check("R11 limit", cfg_rdata, 32'h007F_FF00);
        cfg_sel = 2'd1; #1 check("R11 aux base", cfg_rdata, 32'h1FA0_0000);
        cfg_sel = 2'd2; #1 check("R11 aux dly", cfg_rdata, 32'h0015_2E35);
        cfg_sel = 2'd3; #1 check("R11 boot dly", cfg_rdata, 32'h0016_2456);

        // R1 explicit: 0xA0000100 and 0x00000100 are both main memory
        request(32'hA000_0100, 32'd8, 1'b0);
        check("R1 segment stripped", {rsp_ok, rsp_win}, 3'b101);
        // R3: last 256 bytes of main memory rejected
        request(32'h007F_FF00, 32'd8, 1'b0);
        check("R3 above limit", rsp_ok, 0);
        // R9: idle after request
        @(negedge clk);
        check("R9 idle", {rsp_valid, rsp_ok, rsp_win, rsp_img}, 0);

        sweep(1'b0);
        sweep(1'b1);

        // Move aux window, shrink boot to 2 MB, then sweep again
        cfg_write(2'd1, 32'h1E00_0000);
        cfg_write(2'd2, 32'h0018_3F56);
        cfg_write(2'd3, 32'h0000_0015);
        sweep(1'b0);
        // R7 priority: aux overlaps boot -> boot wins; main covers all -> main wins
        cfg_write(2'd1, 32'h1FC0_0000);
        request(32'h1FC0_0000, 32'd8, 1'b1);
        check("R7 boot over aux", rsp_win, 2);
        cfg_write(2'd0, 32'h2000_0000);
        request(32'hBFC0_0000, 32'd8, 1'b0);
        check("R7 main over boot", rsp_win, 1);
        sweep(1'b1);

        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end
endmodule